// File: doc/BRIEF.md
# Display Timing Counter Chain

This block produces every horizontal and vertical timing signal a caption display path needs, starting from one dot clock. A dot counter divides the dot clock into character slots. A character counter then divides those into lines and gives a line-end strobe, a strobe on every second line end, and a square wave at line rate. A line counter numbers the lines from 1 upward within each field and alternates between a shorter and a longer field. Decoders built on the line number give a gate for the caption data line and a window for the active display rows. A scroll tick is also taken from the line-end strobe.

A vertical phase pulse from the vertical lock logic restarts the whole chain. It carries the identity of the field it marks, so that the display locks to incoming video. Between pulses the chain runs freely. With the default parameters, a 12 MHz dot clock, 12 dots per character and 64 characters per line give a line period close to the broadcast standard. The fields have 262 and 263 lines, the caption line is line 21 and the display window covers lines 43 to 237.

Top module: `disp_timing_chain`

## Requirements
- R1: While `rst_n` is low, `line_num` is 1, `field` is 0, `hsqr` is 1 and `char_stb`, `h_stb`, `h2_stb` and `scroll_stb` are 0. Counting starts from dot 0 of character 0 when reset is released.
- R2: `char_stb` is high for exactly one dot clock, on the last dot of every character slot. It therefore pulses every `DOTS_PER_CHAR` cycles.
- R3: `h_stb` is high for one cycle, on the last dot of the last character of each line, which is every `DOTS_PER_CHAR*CHARS_PER_LINE` cycles.
- R4: `h2_stb` goes high together with every second `h_stb`. The first one comes at the end of the second line after a reset or a restart.
- R5: `hsqr` is 1 while the character index is below `CHARS_PER_LINE/2` and 0 for the remaining characters of the line.
- R6: `line_num` counts from 1 and advances by one in the cycle after each `h_stb`. Field 0 (`field`=0) has `LINES_F0` lines and field 1 has `LINES_F1` lines. After the last line of a field, the count returns to 1 and `field` inverts.
- R7: When `v_reset` is high at a clock edge, the chain restarts after that edge: dot 0, character 0, line 1, `field` equal to `v_field`, and the 2H and scroll phases cleared.
- R8: `cap_gate` is high for the whole of line `CAPTION_LINE` in both fields and low on every other line.
- R9: `disp_win` is high exactly on lines `WIN_FIRST` to `WIN_LAST` inclusive, in both fields.
- R10: `scroll_stb` goes high together with `h_stb` at the end of every `SCROLL_LINES`-th line counted since reset or restart. This count continues across field boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| v_reset | input | 1 | Vertical phase pulse, restarts the chain |
| v_field | input | 1 | Field identity loaded on `v_reset` |
| char_stb | output | 1 | Character-slot strobe |
| h_stb | output | 1 | Line-end strobe |
| h2_stb | output | 1 | Strobe on every second line end |
| hsqr | output | 1 | Line-rate square wave |
| line_num | output | LINE_W | Line number within the field, from 1 |
| field | output | 1 | Current field |
| cap_gate | output | 1 | Caption line gate |
| disp_win | output | 1 | Display-active window |
| scroll_stb | output | 1 | Smooth-scroll tick |

## Verification
The bench builds the chain with 3 dots per character, 6 characters per line, fields of 12 and 13 lines, caption line 3, window lines 5 to 9 and a scroll period of 4 lines. One frame is then only 450 cycles, so every dot of several whole frames is compared against values derived from the elapsed cycle count. This covers both field wraps, the odd-length field that shifts the 2H phase, and scroll ticks that cross field boundaries. Restart pulses are placed in the middle of lines with each field identity, and one reset is applied mid-run.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
   // Width that holds values 0..n-1, at least one bit
   function automatic int dtc_width(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic int dtc_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/dtc_dot_div.sv
module dtc_dot_div #(
   parameter int DOTS_PER_CHAR  = 12,
   parameter int CHARS_PER_LINE = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic chr_tick,
   output logic line_tick,
   output logic hsqr
);
   import dtc_pkg::*;

   localparam int DW = dtc_width(DOTS_PER_CHAR);
   localparam int CW = dtc_width(CHARS_PER_LINE);
   localparam logic [DW-1:0] DOT_LAST  = DW'(DOTS_PER_CHAR - 1);
   localparam logic [CW-1:0] CHAR_LAST = CW'(CHARS_PER_LINE - 1);
   localparam logic [CW-1:0] CHAR_HALF = CW'(CHARS_PER_LINE / 2);
   localparam bit DOT_POW2 = (DOTS_PER_CHAR & (DOTS_PER_CHAR - 1)) == 0;

   logic [DW-1:0] dot_q;
   logic [CW-1:0] chr_q;

   assign chr_tick  = (dot_q == DOT_LAST);
   assign line_tick = chr_tick && (chr_q == CHAR_LAST);
   assign hsqr      = (chr_q < CHAR_HALF);

   generate
      if (DOT_POW2) begin : g_dot_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       dot_q <= '0;
            else if (restart) dot_q <= '0;
            else              dot_q <= dot_q + DW'(1);
         end
      end else begin : g_dot_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        dot_q <= '0;
            else if (restart)  dot_q <= '0;
            else if (chr_tick) dot_q <= '0;
            else               dot_q <= dot_q + DW'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         chr_q <= '0;
      else if (restart)   chr_q <= '0;
      else if (line_tick) chr_q <= '0;
      else if (chr_tick)  chr_q <= chr_q + CW'(1);
   end

   // R2
   dot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dot_q <= DOT_LAST);

   // R3
   char_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chr_q <= CHAR_LAST);
endmodule

// File: rtl/dtc_line_ctr.sv
module dtc_line_ctr #(
   parameter int LINES_F0 = 262,
   parameter int LINES_F1 = 263,
   parameter int LW       = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          restart_fld,
   input  logic          line_tick,
   output logic [LW-1:0] line_num,
   output logic          field,
   output logic          line2_tick
);
   localparam logic [LW-1:0] F0_LAST  = LW'(LINES_F0);
   localparam logic [LW-1:0] F1_LAST  = LW'(LINES_F1);
   localparam logic [LW-1:0] LINE_ONE = LW'(1);

   logic [LW-1:0] line_q;
   logic          fld_q;
   logic          half_q;
   logic [LW-1:0] field_last;

   assign field_last = fld_q ? F1_LAST : F0_LAST;
   assign line_num   = line_q;
   assign field      = fld_q;
   assign line2_tick = line_tick && half_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= LINE_ONE;
         fld_q  <= 1'b0;
         half_q <= 1'b0;
      end else if (restart) begin
         line_q <= LINE_ONE;
         fld_q  <= restart_fld;
         half_q <= 1'b0;
      end else if (line_tick) begin
         half_q <= ~half_q;
         if (line_q == field_last) begin
            line_q <= LINE_ONE;
            fld_q  <= ~fld_q;
         end else begin
            line_q <= line_q + LINE_ONE;
         end
      end
   end

   // R6
   field_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_tick && !restart && line_q == field_last)
      |=> (line_q == LINE_ONE && fld_q != $past(fld_q)));

   // R6
   line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_q >= LINE_ONE && line_q <= field_last);

   // R7
   restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (line_q == LINE_ONE && fld_q == $past(restart_fld)));
endmodule

// File: rtl/dtc_decode.sv
module dtc_decode #(
   parameter int LW           = 9,
   parameter int CAPTION_LINE = 21,
   parameter int WIN_FIRST    = 43,
   parameter int WIN_LAST     = 237,
   parameter int SCROLL_LINES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          line_tick,
   input  logic [LW-1:0] line_num,
   output logic          cap_gate,
   output logic          disp_win,
   output logic          scroll_tick
);
   import dtc_pkg::*;

   localparam logic [LW-1:0] CAP_L = LW'(CAPTION_LINE);
   localparam logic [LW-1:0] WF_L  = LW'(WIN_FIRST);
   localparam logic [LW-1:0] WL_L  = LW'(WIN_LAST);
   localparam int SW = dtc_width(SCROLL_LINES);

   assign cap_gate = (line_num == CAP_L);
   assign disp_win = (line_num >= WF_L) && (line_num <= WL_L);

   generate
      if (SCROLL_LINES == 1) begin : g_scroll_each
         assign scroll_tick = line_tick;
      end else begin : g_scroll_div
         localparam logic [SW-1:0] SC_LAST = SW'(SCROLL_LINES - 1);
         logic [SW-1:0] sc_q;
         assign scroll_tick = line_tick && (sc_q == SC_LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           sc_q <= '0;
            else if (restart)     sc_q <= '0;
            else if (scroll_tick) sc_q <= '0;
            else if (line_tick)   sc_q <= sc_q + SW'(1);
         end
         // R10
         scroll_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sc_q <= SC_LAST);
      end
   endgenerate

   // R8
   cap_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_gate) |-> $past(line_tick || restart));
endmodule

// File: rtl/disp_timing_chain.sv
module disp_timing_chain #(
   parameter int DOTS_PER_CHAR  = 12,
   parameter int CHARS_PER_LINE = 64,
   parameter int LINES_F0       = 262,
   parameter int LINES_F1       = 263,
   parameter int CAPTION_LINE   = 21,
   parameter int WIN_FIRST      = 43,
   parameter int WIN_LAST       = 237,
   parameter int SCROLL_LINES   = 2,
   parameter int LINE_W = dtc_pkg::dtc_width(dtc_pkg::dtc_max(LINES_F0, LINES_F1) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              v_reset,
   input  logic              v_field,
   output logic              char_stb,
   output logic              h_stb,
   output logic              h2_stb,
   output logic              hsqr,
   output logic [LINE_W-1:0] line_num,
   output logic              field,
   output logic              cap_gate,
   output logic              disp_win,
   output logic              scroll_stb
);
   localparam int MAX_LINES = dtc_pkg::dtc_max(LINES_F0, LINES_F1);

   generate
      if (DOTS_PER_CHAR < 2)   begin : g_bad_dpc  $error("DOTS_PER_CHAR must be 2 or more"); end
      if (CHARS_PER_LINE < 2)  begin : g_bad_cpl  $error("CHARS_PER_LINE must be 2 or more"); end
      if (LINES_F0 < 2 || LINES_F1 < 2) begin : g_bad_fld $error("each field needs 2 or more lines"); end
      if ((1 << LINE_W) <= MAX_LINES) begin : g_bad_lw $error("LINE_W too narrow for the line count"); end
      if (WIN_FIRST < 1 || WIN_LAST < WIN_FIRST) begin : g_bad_win $error("display window bounds invalid"); end
      if (CAPTION_LINE < 1 || CAPTION_LINE > MAX_LINES) begin : g_bad_cap $error("caption line out of range"); end
      if (SCROLL_LINES < 1)    begin : g_bad_scr  $error("SCROLL_LINES must be 1 or more"); end
   endgenerate

   logic chr_tick, line_tick, line2_tick, sq;

   dtc_dot_div #(
      .DOTS_PER_CHAR (DOTS_PER_CHAR),
      .CHARS_PER_LINE(CHARS_PER_LINE)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (v_reset),
      .chr_tick (chr_tick),
      .line_tick(line_tick),
      .hsqr     (sq)
   );

   dtc_line_ctr #(
      .LINES_F0(LINES_F0),
      .LINES_F1(LINES_F1),
      .LW      (LINE_W)
   ) u_lines (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (v_reset),
      .restart_fld(v_field),
      .line_tick  (line_tick),
      .line_num   (line_num),
      .field      (field),
      .line2_tick (line2_tick)
   );

   dtc_decode #(
      .LW          (LINE_W),
      .CAPTION_LINE(CAPTION_LINE),
      .WIN_FIRST   (WIN_FIRST),
      .WIN_LAST    (WIN_LAST),
      .SCROLL_LINES(SCROLL_LINES)
   ) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (v_reset),
      .line_tick  (line_tick),
      .line_num   (line_num),
      .cap_gate   (cap_gate),
      .disp_win   (disp_win),
      .scroll_tick(scroll_stb)
   );

   assign char_stb = chr_tick;
   assign h_stb    = line_tick;
   assign h2_stb   = line2_tick;
   assign hsqr     = sq;

   // R5
   line_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_stb && !v_reset) |=> hsqr);

   // R4
   h2_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h2_stb && !v_reset) |=> !h2_stb);
endmodule

// File: tb/sim_disp_timing_chain.sv
module sim_disp_timing_chain;
   localparam int DPC = 3;
   localparam int CPL = 6;
   localparam int F0  = 12;
   localparam int F1  = 13;
   localparam int CAP = 3;
   localparam int WF  = 5;
   localparam int WL  = 9;
   localparam int SD  = 4;
   localparam int LW  = 4;
   localparam int RUN = 3200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic v_reset = 1'b0;
   logic v_field = 1'b0;
   logic char_stb, h_stb, h2_stb, hsqr, field, cap_gate, disp_win, scroll_stb;
   logic [LW-1:0] line_num;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   int t = 0;
   int base = 0;

   always #5 clk = ~clk;

   disp_timing_chain #(
      .DOTS_PER_CHAR(DPC), .CHARS_PER_LINE(CPL), .LINES_F0(F0), .LINES_F1(F1),
      .CAPTION_LINE(CAP), .WIN_FIRST(WF), .WIN_LAST(WL), .SCROLL_LINES(SD),
      .LINE_W(LW)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .v_reset(v_reset), .v_field(v_field),
      .char_stb(char_stb), .h_stb(h_stb), .h2_stb(h2_stb), .hsqr(hsqr),
      .line_num(line_num), .field(field), .cap_gate(cap_gate),
      .disp_win(disp_win), .scroll_stb(scroll_stb)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s at t=%0d: actual %0d expected %0d", req, what, t, act, exp);
      end
   endtask

   task automatic check_all(input bit in_rst);
      int dot, ch, lines, r, e_line, e_fld;
      bit e_chr, e_h;
      dot   = t % DPC;
      ch    = (t / DPC) % CPL;
      lines = t / (DPC * CPL);
      r     = lines % (F0 + F1);
      if (base == 0) begin
         if (r < F0) begin e_line = r + 1; e_fld = 0; end
         else        begin e_line = r - F0 + 1; e_fld = 1; end
      end else begin
         if (r < F1) begin e_line = r + 1; e_fld = 1; end
         else        begin e_line = r - F1 + 1; e_fld = 0; end
      end
      e_chr = (dot == DPC - 1);
      e_h   = e_chr && (ch == CPL - 1);
      if (in_rst) begin
         // R1 reset state
         chk("R1", "line_num", int'(line_num), 1);
         chk("R1", "field", int'(field), 0);
         chk("R1", "hsqr", int'(hsqr), 1);
         chk("R1", "strobes", int'({char_stb, h_stb, h2_stb, scroll_stb}), 0);
      end else begin
         chk("R2", "char_stb", int'(char_stb), int'(e_chr));
         chk("R3", "h_stb", int'(h_stb), int'(e_h));
         chk("R4", "h2_stb", int'(h2_stb), int'(e_h && (lines % 2 == 1)));
         chk("R5", "hsqr", int'(hsqr), int'(ch < CPL / 2));
         chk("R6", "line_num", int'(line_num), e_line);
         chk("R6", "field", int'(field), e_fld);
         chk("R8", "cap_gate", int'(cap_gate), int'(e_line == CAP));
         chk("R9", "disp_win", int'(disp_win), int'(e_line >= WF && e_line <= WL));
         chk("R10", "scroll_stb", int'(scroll_stb), int'(e_h && (lines % SD == SD - 1)));
      end
   endtask

   initial begin
      for (int n = 0; n < RUN; n++) begin
         @(negedge clk);
         check_all(!rst_n);
         // drive inputs for the next rising edge
         rst_n   = !(n < 3 || (n >= 2600 && n < 2603));
         v_reset = 1'b0;
         // R7 restarts mid-line with each field identity
         if (n == 1000) begin v_reset = 1'b1; v_field = 1'b1; end
         if (n == 1777) begin v_reset = 1'b1; v_field = 1'b0; end
         if (n == 2200) begin v_reset = 1'b1; v_field = 1'b1; end
         if (!rst_n)       begin t = 0; base = 0; end
         else if (v_reset) begin t = 0; base = int'(v_field); end
         else              t++;
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule